// File: doc/BRIEF.md
# Configurable Output Macrocell Array

This block models the output stage of a small programmable logic device: a row of eight macrocells between the AND/OR array and the device pins. Each cell takes one sum-of-products term (its data) and one dedicated product term (usable as a per-cell enable). It produces a pin value, a pin enable, and a feedback bit that goes back into the logic array. A static configuration word sets the cells up. Two global bits pick one of three operating modes for the whole row. Each cell also has a polarity bit and a direction bit.

The mode decides three things: whether a cell's data passes through a flip-flop, where each pin enable comes from, and how feedback is routed. In some modes a cell's feedback comes from a neighbouring pin rather than its own pin. The two shared pins act as a clock and an active-low global enable in registered mode. In the other modes they act as plain inputs that occupy the feedback slots of the two outermost cells. The flip-flops are clocked by `clk`, which stands for the shared clock pin. The logic array, the programming path and the pad drivers sit outside this block.

Top module: `pld_macrocell_array`

## Requirements
- R1: The mode comes from (`cfg_syn`,`cfg_ac0`) as follows: (1,0) is simple, (1,1) is complex and (0,1) is registered. The remaining code (0,0) behaves exactly like simple.
- R2: In simple and complex modes, and for any cell with `cfg_dir`=1 in registered mode, `out_val[i]` equals `sop[i]` XOR `cfg_pol[i]`.
- R3: In simple mode, `out_en[i]` equals NOT `cfg_dir[i]`. The exception is the two innermost cells (3 and 4), whose enable is always 1.
- R4: In simple mode, feedback is taken from neighbouring pins. `fb[i]` is the pin of cell i-1 for i=1..3 and the pin of cell i+1 for i=4..6. `fb[0]` is `shr_a_in` and `fb[7]` is `shr_b_in`. The pins of cells 3 and 4 reach no feedback.
- R5: In complex mode, `out_en[i]` equals NOT `cfg_dir[i]` AND `pterm[i]`.
- R6: In complex mode, `fb[i]` is cell i's own pin for i=1..6. `fb[0]` is `shr_a_in` and `fb[7]` is `shr_b_in`.
- R7: In registered mode, a cell with `cfg_dir`=0 drives `out_val` = q XOR `cfg_pol`, where q captures `sop` on each rising edge of `clk`. Its `out_en` is NOT `shr_b_in`, so the global enable is active low.
- R8: In registered mode, a cell with `cfg_dir`=0 returns the inverted flip-flop state (NOT q) on `fb`.
- R9: In registered mode, a cell with `cfg_dir`=1 is combinational. Its `out_en` is `pterm[i]` and its `fb[i]` is its own pin.
- R10: A cell's pin value is `out_val` when `out_en` is 1 and `pin_in` otherwise. Every feedback that reads a pin sees this value.
- R11: With `rst_n` low at a rising edge, every flip-flop clears to 0. In registered mode this shows as `out_val`=`cfg_pol` and `fb`=1.
- R12: In registered mode, `shr_a_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (the shared clock pin) |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flops |
| cfg_syn | input | 1 | Global mode bit, static |
| cfg_ac0 | input | 1 | Global mode bit, static |
| cfg_pol | input | 8 | Per-cell output polarity, 1 inverts |
| cfg_dir | input | 8 | Per-cell direction / combinational select |
| sop | input | 8 | Sum-of-products data term per cell |
| pterm | input | 8 | Dedicated product term per cell |
| pin_in | input | 8 | External level on each cell pin |
| shr_a_in | input | 1 | Shared pin A: clock in registered mode, input otherwise |
| shr_b_in | input | 1 | Shared pin B: active-low enable in registered mode, input otherwise |
| out_val | output | 8 | Value driven on each cell pin |
| out_en | output | 8 | Pin driver enable per cell |
| fb | output | 8 | Feedback bits returned to the logic array |

## Verification
The data terms are tried with alternating and half-split patterns under several polarity words. These patterns separate a polarity fault from a swapped-cell fault. Direction words that disable some outer cells while driving distinct `pin_in` values show whether feedback reads the driven value or the external level. They also reveal whether simple mode takes feedback from the correct neighbour, and whether the inner cells stay enabled. Sequences of `sop` across clock edges in registered mode, together with toggling of both shared pins, tell registered paths from combinational ones. They also show whether the global enable is active low and whether pin A is truly ignored.

// File: rtl/pld_mc_pkg.sv
// Package pld_mc_pkg
// Shared mode type and the decoder function for the macrocell array.
// Assumes the configuration bits are static during operation.
package pld_mc_pkg;

    typedef enum logic [1:0] {
        MODE_SIMPLE  = 2'd0,
        MODE_COMPLEX = 2'd1,
        MODE_REG     = 2'd2
    } mc_mode_e;

    // Maps the two global bits to a mode; the unused code falls back to simple.
    function automatic mc_mode_e decode_mode(input logic syn, input logic ac0);
        if (!syn && ac0)     return MODE_REG;
        else if (syn && ac0) return MODE_COMPLEX;
        else                 return MODE_SIMPLE;
    endfunction

endpackage

// File: rtl/pld_mode_decode.sv
// Module pld_mode_decode
// Turns the two global configuration bits into the array-wide mode.
// Assumes the bits are static; pure combinational.
module pld_mode_decode
    import pld_mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     syn,
    input  logic     ac0,
    output mc_mode_e mode
);

    // Purpose: decode the global mode bits.
    always_comb begin
        mode = decode_mode(syn, ac0);
    end

    // R1
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!syn && !ac0) |-> (mode == MODE_SIMPLE));

    // R1
    reg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REG) |-> (!syn && ac0));

endmodule

// File: rtl/pld_mc_cell.sv
// Module pld_mc_cell
// One output macrocell: flip-flop, polarity, enable selection and pin value.
// Assumes INNER marks a cell that must always drive in simple mode.
module pld_mc_cell
    import pld_mc_pkg::*;
#(
    parameter bit INNER = 1'b0
)(
    input  logic     clk,
    input  logic     rst_n,
    input  mc_mode_e mode,
    input  logic     pol,
    input  logic     dir,
    input  logic     sop,
    input  logic     pterm,
    input  logic     goe_n,
    input  logic     pin_in,
    output logic     out_val,
    output logic     out_en,
    output logic     pin_val,
    output logic     reg_fb
);

    logic q;

    // Purpose: capture the data term on each rising edge, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= sop;
    end

    // Purpose: select the driven value and enable for the current mode.
    always_comb begin
        out_val = sop ^ pol;
        out_en  = 1'b0;
        unique case (mode)
            MODE_SIMPLE:  out_en = INNER ? 1'b1 : ~dir;
            MODE_COMPLEX: out_en = ~dir & pterm;
            MODE_REG: begin
                if (dir) begin
                    out_en = pterm;
                end else begin
                    out_val = q ^ pol;
                    out_en  = ~goe_n;
                end
            end
            default: out_en = 1'b0;
        endcase
    end

    // Purpose: resolve the level seen on the pin and the inverted register output.
    always_comb begin
        pin_val = out_en ? out_val : pin_in;
        reg_fb  = ~q;
    end

    // R7
    reg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REG && !dir && $past(rst_n) && $stable(pol))
        |-> (out_val == ($past(sop) ^ pol)));

    // R5
    complex_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMPLEX && !pterm) |-> !out_en);

    // R8
    reg_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (reg_fb == !$past(sop)));

    generate
        if (INNER) begin : g_inner_chk
            // R3
            inner_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == MODE_SIMPLE) |-> out_en);
        end
    endgenerate

endmodule

// File: rtl/pld_fb_route.sv
// Module pld_fb_route
// Routes feedback to the logic array according to mode and neighbours.
// Assumes N is even and at least 4; outer cells may take the shared pins.
module pld_fb_route
    import pld_mc_pkg::*;
#(
    parameter int N = 8
)(
    input  logic         clk,
    input  logic         rst_n,
    input  mc_mode_e     mode,
    input  logic [N-1:0] pin_val,
    input  logic [N-1:0] reg_fb,
    input  logic [N-1:0] dir,
    input  logic         sh_a,
    input  logic         sh_b,
    output logic [N-1:0] fb
);

    localparam int HALF = N / 2;

    generate
        for (genvar i = 0; i < N; i++) begin : g_fb
            logic own_reg;
            logic simple_src;
            logic complex_src;

            // Purpose: registered-mode source, flip-flop or own pin.
            always_comb own_reg = dir[i] ? pin_val[i] : reg_fb[i];

            if (i == 0) begin : g_first
                always_comb begin
                    simple_src  = sh_a;
                    complex_src = sh_a;
                end
            end else if (i == N - 1) begin : g_last
                always_comb begin
                    simple_src  = sh_b;
                    complex_src = sh_b;
                end
            end else if (i < HALF) begin : g_low
                always_comb begin
                    simple_src  = pin_val[i-1];
                    complex_src = pin_val[i];
                end
            end else begin : g_high
                always_comb begin
                    simple_src  = pin_val[i+1];
                    complex_src = pin_val[i];
                end
            end

            // Purpose: choose the feedback source for this cell.
            always_comb begin
                unique case (mode)
                    MODE_COMPLEX: fb[i] = complex_src;
                    MODE_REG:     fb[i] = own_reg;
                    default:      fb[i] = simple_src;
                endcase
            end
        end
    endgenerate

    // R6
    complex_outer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMPLEX) |-> (fb[0] == sh_a && fb[N-1] == sh_b));

    // R4
    simple_nbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SIMPLE) |-> (fb[HALF-1] == pin_val[HALF-2] && fb[HALF] == pin_val[HALF+1]));

endmodule

// File: rtl/pld_macrocell_array.sv
// Module pld_macrocell_array
// Row of output macrocells with a global mode and shared clock/enable pins.
// Assumes configuration inputs are static; clk stands for the shared clock pin.
module pld_macrocell_array
    import pld_mc_pkg::*;
#(
    parameter int NCELL = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_syn,
    input  logic             cfg_ac0,
    input  logic [NCELL-1:0] cfg_pol,
    input  logic [NCELL-1:0] cfg_dir,
    input  logic [NCELL-1:0] sop,
    input  logic [NCELL-1:0] pterm,
    input  logic [NCELL-1:0] pin_in,
    input  logic             shr_a_in,
    input  logic             shr_b_in,
    output logic [NCELL-1:0] out_val,
    output logic [NCELL-1:0] out_en,
    output logic [NCELL-1:0] fb
);

    localparam int HALF = NCELL / 2;

    mc_mode_e         mode;
    logic [NCELL-1:0] pin_val;
    logic [NCELL-1:0] reg_fb;

    pld_mode_decode u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .syn   (cfg_syn),
        .ac0   (cfg_ac0),
        .mode  (mode)
    );

    generate
        for (genvar i = 0; i < NCELL; i++) begin : g_cell
            pld_mc_cell #(
                .INNER ((i == HALF - 1) || (i == HALF))
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .mode    (mode),
                .pol     (cfg_pol[i]),
                .dir     (cfg_dir[i]),
                .sop     (sop[i]),
                .pterm   (pterm[i]),
                .goe_n   (shr_b_in),
                .pin_in  (pin_in[i]),
                .out_val (out_val[i]),
                .out_en  (out_en[i]),
                .pin_val (pin_val[i]),
                .reg_fb  (reg_fb[i])
            );
        end
    endgenerate

    pld_fb_route #(.N(NCELL)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .pin_val (pin_val),
        .reg_fb  (reg_fb),
        .dir     (cfg_dir),
        .sh_a    (shr_a_in),
        .sh_b    (shr_b_in),
        .fb      (fb)
    );

    // R10
    pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMPLEX && out_en[1]) |-> (fb[1] == out_val[1]));

endmodule

// File: tb/pld_macrocell_array_bench.sv
// Bench pld_macrocell_array_bench
// Directed scenarios; expected values are derived from the written requirements.
module pld_macrocell_array_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_syn = 1'b0;
    logic         cfg_ac0 = 1'b1;
    logic [N-1:0] cfg_pol = '0;
    logic [N-1:0] cfg_dir = '0;
    logic [N-1:0] sop = '0;
    logic [N-1:0] pterm = '0;
    logic [N-1:0] pin_in = '0;
    logic         shr_a_in = 1'b0;
    logic         shr_b_in = 1'b0;
    logic [N-1:0] out_val;
    logic [N-1:0] out_en;
    logic [N-1:0] fb;

    logic [N-1:0] q_model = '0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Purpose: track what the flip-flops must hold after each edge.
    always @(posedge clk) q_model <= rst_n ? sop : '0;

    pld_macrocell_array u_pld_macrocell_array (
        .clk(clk), .rst_n(rst_n), .cfg_syn(cfg_syn), .cfg_ac0(cfg_ac0),
        .cfg_pol(cfg_pol), .cfg_dir(cfg_dir), .sop(sop), .pterm(pterm),
        .pin_in(pin_in), .shr_a_in(shr_a_in), .shr_b_in(shr_b_in),
        .out_val(out_val), .out_en(out_en), .fb(fb)
    );

    task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Expected outputs from the requirement text (R2..R10).
    task automatic expect_all(output logic [N-1:0] ev, output logic [N-1:0] ee, output logic [N-1:0] ef);
        logic [N-1:0] pin;
        int m; // 0 simple, 1 complex, 2 registered
        if (!cfg_syn && cfg_ac0) m = 2;
        else if (cfg_syn && cfg_ac0) m = 1;
        else m = 0;
        for (int i = 0; i < N; i++) begin
            ev[i] = sop[i] ^ cfg_pol[i];
            if (m == 0)      ee[i] = (i == 3 || i == 4) ? 1'b1 : !cfg_dir[i];
            else if (m == 1) ee[i] = !cfg_dir[i] && pterm[i];
            else if (cfg_dir[i]) ee[i] = pterm[i];
            else begin
                ev[i] = q_model[i] ^ cfg_pol[i];
                ee[i] = !shr_b_in;
            end
            pin[i] = ee[i] ? ev[i] : pin_in[i];
        end
        for (int i = 0; i < N; i++) begin
            if (m == 2) ef[i] = cfg_dir[i] ? pin[i] : !q_model[i];
            else if (i == 0) ef[i] = shr_a_in;
            else if (i == N-1) ef[i] = shr_b_in;
            else if (m == 1) ef[i] = pin[i];
            else if (i < 4) ef[i] = pin[i-1];
            else ef[i] = pin[i+1];
        end
    endtask

    task automatic step_and_check(input string req);
        logic [N-1:0] ev, ee, ef;
        @(posedge clk);
        #2;
        expect_all(ev, ee, ef);
        chk(req, "out_val", out_val, ev);
        chk(req, "out_en", out_en, ee);
        chk(req, "fb", fb, ef);
    endtask

    task automatic set_mode(input logic s, input logic a);
        @(negedge clk);
        cfg_syn = s;
        cfg_ac0 = a;
    endtask

    task automatic test_reset();
        cfg_pol = 8'h96; cfg_dir = 8'h00; sop = 8'hFF; shr_b_in = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk("R11", "out_val after reset", out_val, 8'h96);
        chk("R11", "fb after reset", fb, 8'hFF);
        chk("R11", "out_en after reset", out_en, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_simple();
        set_mode(1'b1, 1'b0);
        cfg_pol = 8'h0F; cfg_dir = 8'h00; sop = 8'hA5; shr_a_in = 1'b1; shr_b_in = 1'b0;
        step_and_check("R2 R3 R4 simple all outputs");
        @(negedge clk);
        cfg_dir = 8'hFF; pin_in = 8'h5A; sop = 8'h3C; pterm = 8'hFF;
        step_and_check("R3 R4 R10 simple inputs inner forced");
        @(negedge clk);
        cfg_dir = 8'hC3; pin_in = 8'hF0; cfg_pol = 8'hFF; shr_a_in = 1'b0; shr_b_in = 1'b1;
        step_and_check("R4 R10 simple mixed");
    endtask

    task automatic test_reserved();
        set_mode(1'b0, 1'b0);
        cfg_dir = 8'h81; sop = 8'h66; pin_in = 8'h99; cfg_pol = 8'h11; pterm = 8'h00;
        step_and_check("R1 reserved code as simple");
        @(negedge clk);
        #1;
        chk("R1", "inner enables under reserved code", out_en & 8'h18, 8'h18);
    endtask

    task automatic test_complex();
        set_mode(1'b1, 1'b1);
        cfg_dir = 8'h00; pterm = 8'h5A; sop = 8'hA5; pin_in = 8'h0F; cfg_pol = 8'h00;
        shr_a_in = 1'b1; shr_b_in = 1'b0;
        step_and_check("R5 R6 R10 complex pterm enables");
        @(negedge clk);
        cfg_dir = 8'h18; pterm = 8'hFF; sop = 8'hFF; cfg_pol = 8'h81; pin_in = 8'h00;
        step_and_check("R2 R5 R6 complex dir gating");
        @(negedge clk);
        #1;
        chk("R5", "inner cells not forced in complex", out_en & 8'h18, 8'h00);
    endtask

    task automatic test_registered();
        set_mode(1'b0, 1'b1);
        cfg_dir = 8'h00; cfg_pol = 8'h0F; shr_b_in = 1'b0; sop = 8'hC3;
        step_and_check("R7 R8 registered capture");
        @(negedge clk);
        sop = 8'h5A;
        #1;
        chk("R7", "out_val holds until edge", out_val, 8'hC3 ^ 8'h0F);
        step_and_check("R7 R8 registered next edge");
        @(negedge clk);
        shr_b_in = 1'b1;
        step_and_check("R7 global enable deasserted");
    endtask

    task automatic test_reg_comb();
        @(negedge clk);
        cfg_dir = 8'hF0; pterm = 8'h30; sop = 8'h96; pin_in = 8'hCC; cfg_pol = 8'h33; shr_b_in = 1'b0;
        step_and_check("R9 R10 registered-mode combinational cells");
    endtask

    task automatic test_shared_a();
        logic [N-1:0] v0, e0, f0;
        @(negedge clk);
        cfg_dir = 8'h0F; pterm = 8'hFF; shr_a_in = 1'b0;
        #1;
        v0 = out_val; e0 = out_en; f0 = fb;
        shr_a_in = 1'b1;
        #1;
        chk("R12", "out_val with pin A toggled", out_val, v0);
        chk("R12", "out_en with pin A toggled", out_en, e0);
        chk("R12", "fb with pin A toggled", fb, f0);
    endtask

    task automatic test_reset_again();
        @(negedge clk);
        cfg_dir = 8'h00; rst_n = 1'b0; cfg_pol = 8'h00;
        @(posedge clk);
        #2;
        chk("R11", "out_val after mid-run reset", out_val, 8'h00);
        chk("R11", "fb after mid-run reset", fb, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_simple();
        test_reserved();
        test_complex();
        test_registered();
        test_reg_comb();
        test_shared_a();
        test_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule